// File: doc/BRIEF.md
# Lockstep Timing Fault Guard

This block watches a follower display tile whose row-level timing is rebuilt locally from the leader's frame and strobe signals. It checks that the follower stays in step with the leader. At each rising edge of the frame pulse, which comes once per half-frame, it compares the locally generated pair of row-level select bits with the pair received from the leader. Any difference pulls a shared open-drain refresh line low for a fixed number of clocks. The line is wired across every tile on the panel.

Every tile watches that line, the leader included. While the line is low, a tile holds its own timing logic in reset and blanks the display. Once the line is released, the tile keeps the display blank for a fixed number of further frames. The pad is modelled as two pins: one enables the pull-down and one senses the resolved line level. A tile strapped as leader never pulls the line itself. After the block's own reset, the same blanking interval applies before the display may turn on.

Top module: `sync_fault_guard`

## Requirements
- R1: During and just after reset, `rfsh_pull_low` is 0, `timing_rst` is 0 and `blank_req` is 1.
- R2: The level pairs are compared only in the cycle where `frm_in` is 1 and was 0 in the previous cycle. A mismatch while the frame input is held steady has no effect on `rfsh_pull_low`.
- R3: In a follower tile (`is_leader` = 0) with comparison enabled, a frame rise with `lvl_local` != `lvl_leader` makes `rfsh_pull_low` 1 from the next cycle. A difference in bit 1 alone triggers it, and so does a difference in bit 0 alone.
- R4: Once started, `rfsh_pull_low` stays 1 for exactly PULL_CYCLES (16) cycles and then releases on its own.
- R5: `timing_rst` follows the sensed line level (1 when `rfsh_sense` is 0), delayed by SYNC_STAGES (2) clock cycles.
- R6: `blank_req` is 1 whenever `timing_rst` is 1. After `timing_rst` falls, `blank_req` stays 1 until BLANK_FRAMES x 2 = 8 frame rises have been seen.
- R7: With `is_leader` = 1 the block never pulls the line, but a low line still raises `timing_rst` and `blank_req`.
- R8: No new pull starts while `timing_rst` or `blank_req` is 1, even at a frame rise with mismatched levels.
- R9: After reset release, `blank_req` drops only after 8 frame rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_leader | input | 1 | 1 = this tile generates timing and never pulls the line |
| frm_in | input | 1 | Frame pulse, rising once per half-frame |
| lvl_local | input | 2 | Locally generated row-level select pair |
| lvl_leader | input | 2 | Row-level select pair received from the leader |
| rfsh_sense | input | 1 | Resolved level of the shared refresh line (0 = asserted) |
| rfsh_pull_low | output | 1 | Pull-down enable for the open-drain refresh pad |
| timing_rst | output | 1 | Internal reset to the local timing counters |
| blank_req | output | 1 | Forces the display off |

## Verification
The hardest case to reach is a new mismatch that arrives while the block is still recovering from an earlier fault. Comparison is then disabled, so the mismatch must be ignored. The directed part reaches this case by feeding mismatched frame rises through the whole blanking window after a self-triggered fault. The random part overlaps externally driven line pulses with pulses driven by the block itself, and it toggles the leader strap. A per-cycle reference model tracks the pull, reset and blank outputs through all of these cases.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
   localparam int RISES_PER_FRAME = 2;
   localparam int LVL_W = 2;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/sfg_edge_det.sv
module sfg_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise
);
   logic sig_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end
   assign rise = sig & ~sig_q;
endmodule

// File: rtl/sfg_sync.sv
module sfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("sfg_sync: STAGES must be non-negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else if (STAGES == 1) pipe <= d;
            else pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfg_pull_timer.sv
module sfg_pull_timer #(
   parameter int PULL_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);
   localparam int CW = $clog2(PULL_CYCLES + 1);
   logic [CW-1:0] left;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (left != '0) left <= left - 1'b1;
      else if (fire)       left <= CW'(PULL_CYCLES);
   end
   assign active = (left != '0);
endmodule

// File: rtl/sfg_blank_timer.sv
module sfg_blank_timer #(
   parameter int BLANK_RISES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic tick,
   output logic blank
);
   localparam int CW = $clog2(BLANK_RISES + 1);
   logic [CW-1:0] remain;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       remain <= CW'(BLANK_RISES);
      else if (hold)                    remain <= CW'(BLANK_RISES);
      else if (tick && remain != '0)    remain <= remain - 1'b1;
   end
   assign blank = hold | (remain != '0);
endmodule

// File: rtl/sync_fault_guard.sv
module sync_fault_guard
   import sfg_pkg::*;
#(
   parameter int PULL_CYCLES  = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int BLANK_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       is_leader,
   input  logic       frm_in,
   input  logic [1:0] lvl_local,
   input  logic [1:0] lvl_leader,
   input  logic       rfsh_sense,
   output logic       rfsh_pull_low,
   output logic       timing_rst,
   output logic       blank_req
);
   localparam int BLANK_RISES = BLANK_FRAMES * RISES_PER_FRAME;

   generate
      if (PULL_CYCLES < 1) begin : g_bad_pull
         $error("sync_fault_guard: PULL_CYCLES must be at least 1");
      end
      if (BLANK_FRAMES < 1) begin : g_bad_blank
         $error("sync_fault_guard: BLANK_FRAMES must be at least 1");
      end
   endgenerate

   logic frm_rise;
   logic line_low_sync;
   logic cmp_en;
   logic mismatch;
   logic fire;

   sfg_edge_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (frm_in),
      .rise (frm_rise)
   );

   sfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (~rfsh_sense),
      .q    (line_low_sync)
   );

   lvl_t loc_v, lead_v;
   assign loc_v    = lvl_local;
   assign lead_v   = lvl_leader;
   assign mismatch = (loc_v != lead_v);
   assign cmp_en   = ~is_leader & ~line_low_sync & ~blank_req;
   assign fire     = frm_rise & cmp_en & mismatch;

   sfg_pull_timer #(.PULL_CYCLES(PULL_CYCLES)) u_pull (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .active(rfsh_pull_low)
   );

   sfg_blank_timer #(.BLANK_RISES(BLANK_RISES)) u_blank (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (line_low_sync),
      .tick (frm_rise),
      .blank(blank_req)
   );

   assign timing_rst = line_low_sync;
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
   parameter int PULL_CYCLES = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       is_leader,
   input logic       frm_in,
   input logic [1:0] lvl_local,
   input logic [1:0] lvl_leader,
   input logic       rfsh_sense,
   input logic       rfsh_pull_low,
   input logic       timing_rst,
   input logic       blank_req
);
   localparam int RW = $clog2(PULL_CYCLES + 2) + 1;
   logic [RW-1:0] run;
   logic [1:0]    age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= '0;
         age <= '0;
      end else begin
         run <= rfsh_pull_low ? run + 1'b1 : '0;
         if (age != 2'd3) age <= age + 1'b1;
      end
   end

   assert_pull_on_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $rose(rfsh_pull_low)) |-> ($past(frm_in) && ($past(lvl_local) != $past(lvl_leader))));

   assert_pull_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_pull_low) |-> (run == RW'(PULL_CYCLES)));

   assert_pull_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RW'(PULL_CYCLES));

   assert_rst_follows_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $rose(timing_rst)) |-> !$past(rfsh_sense));

   assert_rst_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $fell(timing_rst)) |-> $past(rfsh_sense));

   assert_blank_covers_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timing_rst |-> blank_req);

   assert_blank_ends_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $fell(blank_req)) |-> $past(frm_in));

   assert_leader_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $rose(rfsh_pull_low)) |-> !$past(is_leader));

   assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $rose(rfsh_pull_low)) |-> (!$past(timing_rst) && !$past(blank_req)));
endmodule

bind sync_fault_guard sfg_checker #(.PULL_CYCLES(PULL_CYCLES)) u_sfg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .is_leader    (is_leader),
   .frm_in       (frm_in),
   .lvl_local    (lvl_local),
   .lvl_leader   (lvl_leader),
   .rfsh_sense   (rfsh_sense),
   .rfsh_pull_low(rfsh_pull_low),
   .timing_rst   (timing_rst),
   .blank_req    (blank_req)
);

// File: tb/test_sync_fault_guard.sv
`timescale 1ns/1ps
module test_sync_fault_guard;
   localparam int PULL = 16;
   localparam int BLNK = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_leader = 1'b0;
   logic       frm_in = 1'b0;
   logic [1:0] lvl_local = 2'b00;
   logic [1:0] lvl_leader = 2'b00;
   logic       ext_low = 1'b0;
   logic       rfsh_sense;
   logic       rfsh_pull_low, timing_rst, blank_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   assign rfsh_sense = !(rfsh_pull_low | ext_low);

   always #10 clk = ~clk;

   sync_fault_guard i_sync_fault_guard (
      .clk(clk), .rst_n(rst_n), .is_leader(is_leader), .frm_in(frm_in),
      .lvl_local(lvl_local), .lvl_leader(lvl_leader), .rfsh_sense(rfsh_sense),
      .rfsh_pull_low(rfsh_pull_low), .timing_rst(timing_rst), .blank_req(blank_req)
   );

   // reference model state
   int m_pull, m_bcnt;
   bit m_s1, m_s2, m_fprev;

   function automatic bit exp_drive(); return m_pull != 0; endfunction
   function automatic bit exp_rst();   return m_s2; endfunction
   function automatic bit exp_blank(); return m_s2 || (m_bcnt != 0); endfunction

   task automatic model_reset();
      m_pull = 0; m_bcnt = BLNK; m_s1 = 0; m_s2 = 0; m_fprev = 0;
   endtask

   task automatic model_step();
      bit rise, line_low, en;
      int n_pull, n_b;
      rise     = frm_in && !m_fprev;
      line_low = exp_drive() || ext_low;
      en       = !is_leader && !exp_rst() && !exp_blank();
      if (m_pull != 0) n_pull = m_pull - 1;
      else if (rise && en && (lvl_local != lvl_leader)) n_pull = PULL;
      else n_pull = 0;
      if (m_s2) n_b = BLNK;
      else if (rise && m_bcnt != 0) n_b = m_bcnt - 1;
      else n_b = m_bcnt;
      m_s2 = m_s1; m_s1 = line_low; m_fprev = frm_in;
      m_pull = n_pull; m_bcnt = n_b;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: model advances with the inputs now applied, then outputs are compared mid-cycle
   task automatic step();
      model_step();
      @(negedge clk);
      chk("R4 pull", rfsh_pull_low, exp_drive());
      chk("R5 reset", timing_rst, exp_rst());
      chk("R6 blank", blank_req, exp_blank());
   endtask

   task automatic frame_pulse();
      frm_in = 1'b1; step();
      frm_in = 1'b0; step(); step();
   endtask

   task automatic recover();
      for (int k = 0; k < 200 && (blank_req || rfsh_pull_low); k++) frame_pulse();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int rise_at, rst_at, plen;
      process::self().srandom(32'h5F61_0C2B);
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 pull in reset", rfsh_pull_low, 0);
      chk("R1 blank in reset", blank_req, 1);
      rst_n = 1'b1;
      step();
      chk("R1 pull after reset", rfsh_pull_low, 0);
      chk("R1 reset after reset", timing_rst, 0);
      chk("R1 blank after reset", blank_req, 1);

      // R9: power-up blanking lasts 8 frame rises
      for (int i = 0; i < BLNK - 1; i++) frame_pulse();
      chk("R9 blank before last rise", blank_req, 1);
      frame_pulse();
      chk("R9 blank after 8 rises", blank_req, 0);

      // R2: mismatch with frame held high or low does not trigger
      frm_in = 1'b1; step();
      lvl_local = 2'b01;
      repeat (6) step();
      frm_in = 1'b0;
      repeat (6) step();
      chk("R2 no pull without rise", rfsh_pull_low, 0);

      // R3 bit 1 mismatch, R4 length, R5 delay, R8 no retrigger, R6 blanking
      lvl_local = 2'b10; lvl_leader = 2'b00;
      frm_in = 1'b1; step();
      chk("R3 pull on bit1 mismatch", rfsh_pull_low, 1);
      frm_in = 1'b0;
      rise_at = 0; rst_at = -1; plen = 1;
      for (int c = 1; c < 40; c++) begin
         step();
         if (rfsh_pull_low) plen++;
         if (timing_rst && rst_at < 0) rst_at = c;
      end
      chk("R4 pull length", plen, PULL);
      chk("R5 reset delay", rst_at - rise_at, 2);
      for (int i = 0; i < BLNK - 1; i++) begin
         frame_pulse();
         chk("R8 no retrigger while blank", rfsh_pull_low, 0);
      end
      chk("R6 still blank before 8th rise", blank_req, 1);
      frame_pulse();
      chk("R6 blank done after 8th rise", blank_req, 0);
      chk("R8 no pull after blanking", rfsh_pull_low, 0);

      // R3: bit 0 alone mismatched
      lvl_local = 2'b01; lvl_leader = 2'b00;
      frm_in = 1'b1; step();
      chk("R3 pull on bit0 mismatch", rfsh_pull_low, 1);
      frm_in = 1'b0; lvl_local = 2'b00;
      recover();

      // R7: leader never pulls but obeys the line
      is_leader = 1'b1; lvl_local = 2'b11;
      frame_pulse();
      chk("R7 leader does not pull", rfsh_pull_low, 0);
      ext_low = 1'b1;
      repeat (6) step();
      chk("R7 leader reset by line", timing_rst, 1);
      chk("R7 leader blanked", blank_req, 1);
      ext_low = 1'b0; lvl_local = 2'b00; is_leader = 1'b0;
      recover();

      // constrained random phase
      begin
         int ext_left = 0;
         for (int c = 0; c < 30000; c++) begin
            if (($urandom % 600) == 0) is_leader = ~is_leader;
            frm_in = (($urandom % 4) == 0);
            lvl_local = 2'($urandom);
            lvl_leader = (($urandom % 6) == 0) ? 2'($urandom) : lvl_local;
            if (ext_left > 0) ext_left--;
            else if (($urandom % 400) == 0) ext_left = 3 + ($urandom % 20);
            ext_low = (ext_left > 0);
            step();
         end
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule